// File: doc/BRIEF.md
# Multiport Memory with Last-Writer Table

This block is a storage array with M write ports and N read ports. Every port can be used in every clock cycle, with no stalls and no time sharing. The array is parameterised by depth and data width. The default is 2 write ports and 4 read ports.

The data itself is held in one bank per write port. Each bank holds one simple one-write/one-read RAM copy per read port, and the owning write port writes every copy in its bank. A narrow register table has the same depth as the array and records which write port last wrote each address. Each entry is ceil(log2(M)) bits wide. All write ports update this table in the same cycle that all read ports look it up. On a read, the looked-up entry picks which bank's private copy supplies the data.

Read data has one cycle of latency. Both the table lookup and the bank reads are registered in the same cycle, so the selector and the data it selects always belong to the same cycle.

Top module: `lvt_mpram`

## Requirements
- R1: All write ports and all read ports operate in the same cycle. For any mix of writes and reads, each read port returns the value most recently written to its address.
- R2: Read data appears on `rdata_o` on the clock edge after the read address is sampled. That is exactly one cycle of latency, and the data belongs to that read address only.
- R3: A read of an address that is written in the same cycle returns the value held before that write.
- R4: A write from any port m stores its data at its address. A later read from any read port returns that data.
- R5: When several write ports write the same address in the same cycle, the highest-numbered port wins. Later reads return that port's data.
- R6: When a different write port writes an address later, it replaces the earlier value, so reads return the newest data regardless of port number.
- R7: While `rst_ni` is low, every read port outputs zero.
- R8: A write port whose enable bit is 0 changes nothing, whatever its address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | N_WR | Write enable, bit m for write port m |
| waddr_i | input | N_WR*AW | Write addresses; port m uses bits [m*AW +: AW] |
| wdata_i | input | N_WR*WIDTH | Write data; port m uses bits [m*WIDTH +: WIDTH] |
| raddr_i | input | N_RD*AW | Read addresses; port r uses bits [r*AW +: AW] |
| rdata_o | output | N_RD*WIDTH | Read data, one cycle after the address; port r uses bits [r*WIDTH +: WIDTH] |

## Verification
Suppose the last-writer table holds a wrong entry for some address. The next read of that address returns the other bank's stale data, one cycle after the address is presented. It shows up as a plain data mismatch on the affected read port. Same-address write collisions and overwrites across ports are where a wrong priority or a missed table update becomes visible, so the stimulus crowds writes onto a few addresses. A misaligned selector shows up on the very next read, as data that belongs to a neighbouring cycle's address.

// File: rtl/lvt_mpram_pkg.sv
package lvt_mpram_pkg;
  function automatic int sel_bits(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lvt_sdp_ram.sv
module lvt_sdp_ram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [WIDTH-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read-before-write: array sampled before this edge's update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= mem_q[raddr_i];
  end

  assign rdata_o = rd_q;

  p_wr_store_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] === $past(wdata_i));

  p_rd_old_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i == raddr_i) |=> rd_q === $past(mem_q[raddr_i]));
endmodule

// File: rtl/lvt_bank.sv
module lvt_bank #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  parameter int N_RD  = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [AW-1:0]              waddr_i,
  input  logic [WIDTH-1:0]           wdata_i,
  input  logic [N_RD-1:0][AW-1:0]    raddr_i,
  output logic [N_RD-1:0][WIDTH-1:0] rdata_o
);
  // one private copy per read port, all written together
  for (genvar r = 0; r < N_RD; r++) begin : g_copy
    lvt_sdp_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we_i),
      .waddr_i (waddr_i),
      .wdata_i (wdata_i),
      .raddr_i (raddr_i[r]),
      .rdata_o (rdata_o[r])
    );
  end
endmodule

// File: rtl/lvt_live_table.sv
module lvt_live_table #(
  parameter int DEPTH = 32,
  parameter int N_WR  = 2,
  parameter int N_RD  = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = lvt_mpram_pkg::sel_bits(N_WR)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_WR-1:0]         we_i,
  input  logic [N_WR-1:0][AW-1:0] waddr_i,
  input  logic [N_RD-1:0][AW-1:0] raddr_i,
  output logic [N_RD-1:0][SW-1:0] sel_o
);
  logic [SW-1:0] tbl_q [DEPTH];
  logic [N_RD-1:0][SW-1:0] sel_q;

  // ascending loop: last assignment (highest port) wins on collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int d = 0; d < DEPTH; d++) tbl_q[d] <= '0;
    end else begin
      for (int m = 0; m < N_WR; m++)
        if (we_i[m]) tbl_q[waddr_i[m]] <= SW'(m);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else for (int r = 0; r < N_RD; r++) sel_q[r] <= tbl_q[raddr_i[r]];
  end

  assign sel_o = sel_q;

  // checking aid: another higher port writes the same address this cycle
  logic [N_WR-1:0] hit_above;
  always_comb begin
    hit_above = '0;
    for (int m = 0; m < N_WR; m++)
      for (int k = m + 1; k < N_WR; k++)
        if (we_i[k] && waddr_i[k] == waddr_i[m]) hit_above[m] = 1'b1;
  end

  for (genvar m = 0; m < N_WR; m++) begin : g_chk
    p_last_writer_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i[m] && !hit_above[m]) |=> tbl_q[$past(waddr_i[m])] == SW'(m));
  end

  p_high_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i[N_WR-1] |=> tbl_q[$past(waddr_i[N_WR-1])] == SW'(N_WR-1));

  for (genvar r = 0; r < N_RD; r++) begin : g_sel_chk
    p_sel_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      32'(sel_q[r]) < N_WR);
  end
endmodule

// File: rtl/lvt_mpram.sv
module lvt_mpram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  parameter int N_WR  = 2,
  parameter int N_RD  = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = lvt_mpram_pkg::sel_bits(N_WR)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_WR-1:0]       we_i,
  input  logic [N_WR*AW-1:0]    waddr_i,
  input  logic [N_WR*WIDTH-1:0] wdata_i,
  input  logic [N_RD*AW-1:0]    raddr_i,
  output logic [N_RD*WIDTH-1:0] rdata_o
);
  logic [N_WR-1:0][AW-1:0]    wa;
  logic [N_WR-1:0][WIDTH-1:0] wd;
  logic [N_RD-1:0][AW-1:0]    ra;
  logic [N_RD-1:0][SW-1:0]    sel;
  logic [N_RD-1:0][WIDTH-1:0] bank_rd [N_WR];
  logic [N_RD-1:0][WIDTH-1:0] rd;

  assign wa = waddr_i;
  assign wd = wdata_i;
  assign ra = raddr_i;

  for (genvar m = 0; m < N_WR; m++) begin : g_bank
    lvt_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH), .N_RD(N_RD)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we_i[m]),
      .waddr_i (wa[m]),
      .wdata_i (wd[m]),
      .raddr_i (ra),
      .rdata_o (bank_rd[m])
    );
  end

  lvt_live_table #(.DEPTH(DEPTH), .N_WR(N_WR), .N_RD(N_RD)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .waddr_i (wa),
    .raddr_i (ra),
    .sel_o   (sel)
  );

  // selector and bank data are both registered in the same cycle
  always_comb begin
    for (int r = 0; r < N_RD; r++) rd[r] = bank_rd[sel[r]][r];
  end

  assign rdata_o = rd;

  p_rst_out_zero_r7: assert property (@(posedge clk_i)
    !rst_ni |-> rdata_o == '0);
endmodule

// File: tb/lvt_mpram_test.sv
module lvt_mpram_test;
  localparam int CLK_P = 10;
  localparam int DEPTH = 32;
  localparam int WIDTH = 16;
  localparam int NW = 2;
  localparam int NR = 4;
  localparam int AW = $clog2(DEPTH);

  logic                clk = 1'b0;
  logic                rst_ni = 1'b0;
  logic [NW-1:0]       we_i = '0;
  logic [NW*AW-1:0]    waddr_i = '0;
  logic [NW*WIDTH-1:0] wdata_i = '0;
  logic [NR*AW-1:0]    raddr_i = '0;
  logic [NR*WIDTH-1:0] rdata_o;

  always #(CLK_P/2) clk = ~clk;

  lvt_mpram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .N_WR(NW), .N_RD(NR)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we_i), .waddr_i(waddr_i),
    .wdata_i(wdata_i), .raddr_i(raddr_i), .rdata_o(rdata_o)
  );

  int checks = 0;
  int failures = 0;

  logic [WIDTH-1:0] model [DEPTH];
  bit               known [DEPTH];

  logic [WIDTH-1:0] exp_q [$];
  bit               ok_q [$];
  int               port_q [$];
  string            tag_q [$];

  bit               wb [NW];
  int               wab [NW];
  logic [WIDTH-1:0] wdb [NW];
  int               rab [NR];

  task automatic check(string tag, int port, logic [WIDTH-1:0] got, logic [WIDTH-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s port %0d got %h expected %h", tag, port, got, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected reads
  task automatic step(string tag);
    @(negedge clk);
    for (int m = 0; m < NW; m++) begin
      we_i[m] = wb[m];
      waddr_i[m*AW +: AW] = AW'(wab[m]);
      wdata_i[m*WIDTH +: WIDTH] = wdb[m];
    end
    for (int r = 0; r < NR; r++) begin
      raddr_i[r*AW +: AW] = AW'(rab[r]);
      exp_q.push_back(model[rab[r]]);
      ok_q.push_back(known[rab[r]]);
      port_q.push_back(r);
      tag_q.push_back(tag);
    end
    // ascending order: higher port overrides on collision
    for (int m = 0; m < NW; m++)
      if (wb[m]) begin
        model[wab[m]] = wdb[m];
        known[wab[m]] = 1'b1;
      end
  endtask

  task automatic idle_writes();
    for (int m = 0; m < NW; m++) wb[m] = 1'b0;
  endtask

  // monitor: compares queued expectations one cycle after they were issued
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (exp_q.size() > 0) begin
        logic [WIDTH-1:0] e;
        bit k;
        int p;
        string t;
        e = exp_q.pop_front();
        k = ok_q.pop_front();
        p = port_q.pop_front();
        t = tag_q.pop_front();
        if (k) check(t, p, rdata_o[p*WIDTH +: WIDTH], e);
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int d = 0; d < DEPTH; d++) known[d] = 1'b0;
    for (int m = 0; m < NW; m++) begin wb[m] = 0; wab[m] = 0; wdb[m] = '0; end
    for (int r = 0; r < NR; r++) rab[r] = 0;

    // R7: outputs zero under reset
    repeat (3) @(negedge clk);
    for (int r = 0; r < NR; r++) check("R7", r, rdata_o[r*WIDTH +: WIDTH], '0);
    rst_ni = 1'b1;

    // fill the array, ports splitting even/odd addresses (R4)
    for (int i = 0; i < DEPTH / 2; i++) begin
      wb[0] = 1; wab[0] = 2 * i;     wdb[0] = WIDTH'(16'h1000 + 2 * i);
      wb[1] = 1; wab[1] = 2 * i + 1; wdb[1] = WIDTH'(16'h2000 + 2 * i + 1);
      for (int r = 0; r < NR; r++) rab[r] = (2 * i + r) % DEPTH;
      step("R4");
    end
    idle_writes();
    for (int j = 0; j < DEPTH / NR; j++) begin
      for (int r = 0; r < NR; r++) rab[r] = j * NR + r;
      step("R4");
    end

    // R4: port 1 writes, all read ports read back
    wb[1] = 1; wab[1] = 5; wdb[1] = 16'hBEEF;
    step("R4");
    idle_writes();
    for (int r = 0; r < NR; r++) rab[r] = 5;
    step("R4");

    // R3: same-cycle read of the written address returns old data
    wb[0] = 1; wab[0] = 5; wdb[0] = 16'hC0DE;
    step("R3");
    idle_writes();
    step("R3");

    // R5: both ports hit address 9 together, port 1 must win
    wb[0] = 1; wab[0] = 9; wdb[0] = 16'hAAAA;
    wb[1] = 1; wab[1] = 9; wdb[1] = 16'h5555;
    for (int r = 0; r < NR; r++) rab[r] = 9;
    step("R5");
    idle_writes();
    step("R5");

    // R6: alternating overwrites of one address from different ports
    for (int i = 0; i < 6; i++) begin
      idle_writes();
      wb[i % 2] = 1; wab[i % 2] = 12; wdb[i % 2] = WIDTH'(16'h3300 + i);
      for (int r = 0; r < NR; r++) rab[r] = 12;
      step("R6");
    end
    idle_writes();
    step("R6");

    // R8: disabled ports drive address and data that must be ignored
    wb[0] = 0; wab[0] = 12; wdb[0] = 16'hDEAD;
    wb[1] = 0; wab[1] = 9;  wdb[1] = 16'hDEAD;
    rab[0] = 12; rab[1] = 9; rab[2] = 12; rab[3] = 9;
    step("R8");
    step("R8");

    // R2: address changes every cycle, data must track with one cycle of latency
    idle_writes();
    for (int i = 0; i < 8; i++) begin
      for (int r = 0; r < NR; r++) rab[r] = (i * 3 + r * 7) % DEPTH;
      step("R2");
    end

    // R1: random full-port traffic crowded onto few addresses
    for (int i = 0; i < 400; i++) begin
      for (int m = 0; m < NW; m++) begin
        wb[m] = ($urandom_range(0, 3) != 0);
        wab[m] = $urandom_range(0, 7);
        wdb[m] = WIDTH'($urandom);
      end
      for (int r = 0; r < NR; r++) rab[r] = $urandom_range(0, 7);
      step("R1");
    end
    idle_writes();
    step("R1");
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule